// File: doc/BRIEF.md
# Edge-Triggered Watchdog Supervisor

This block watches a software heartbeat on an asynchronous kick input. It pulls an active-low alarm output whenever the heartbeat stops for longer than a configured timeout. All durations are given as time parameters. At elaboration they are converted into clock-cycle counts from the clock frequency in kHz, so one piece of RTL covers timeouts from a few milliseconds to more than a second. Both asynchronous inputs pass through a two-flop synchronizer and then a level qualifier. The qualifier accepts a new level only after it has held for a set time, so short glitches never reach the timer.

A trigger-policy parameter chooses between two behaviours. In the rising-edge policy only low-to-high kicks restart the timer. The alarm lasts at most one timeout period, and a kick can end the alarm early once a guaranteed minimum low width has passed. In the both-edge policy either kick transition restarts the timer. The alarm then has a fixed length that kicks cannot shorten. In both policies, an inhibit input holds the timer at zero and keeps the output high. If inhibit is raised during an alarm, the alarm is released only after the minimum low width. A two-bit phase output reports whether the block is inhibited, counting or alarming.

Top module: `wdg_supervisor`

## Requirements
- R1: After reset release the timer counts from zero with no kick needed, and the alarm falls after TIMEOUT_NS worth of cycles whatever level the kick input held at start-up.
- R2: With TRIG = TRIG_RISE only a qualified low-to-high kick restarts the timer; a high-to-low kick has no effect on when the alarm falls.
- R3: With TRIG = TRIG_BOTH a qualified kick transition in either direction restarts the timer.
- R4: With TRIG = TRIG_BOTH the alarm stays low for exactly ALARM_NS worth of cycles, and kicks during it change neither its length nor its end.
- R5: With TRIG = TRIG_RISE the alarm lasts at most one timeout period. A rising kick during the alarm releases it once it has been low for MIN_LOW_NS; a kick that comes earlier is held until that width is reached.
- R6: Without kicks the block repeats alarm, release and timeout forever, and every alarm is preceded by at least one full timeout of high output.
- R7: While inhibit is high the alarm output is high, the phase is inhibited and the timer is held at zero; counting restarts from zero when inhibit returns low.
- R8: Inhibit raised during an alarm releases the output only after it has been low for at least MIN_LOW_NS.
- R9: A kick or inhibit level is accepted only after it has held for QUAL_NS; a pulse of 1 us or more is accepted and a glitch shorter than 100 ns is ignored.
- R10: phase_o encodes 0 = inhibited, 1 = counting, 2 = alarm, and 3 never occurs. During reset alarm_n_o is 1 and phase_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, period below 100 ns |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously; models power-on |
| kick_i | input | 1 | Asynchronous heartbeat input |
| inhibit_i | input | 1 | Asynchronous inhibit; high stops supervision |
| alarm_n_o | output | 1 | Registered active-low alarm |
| phase_o | output | 2 | Current phase: 0 inhibited, 1 counting, 2 alarm |

## Verification
The bench drives two copies of the block side by side, one per trigger policy, from the same kick and inhibit waveform. This lets one falling kick expose a rising-only design that accepts falling edges, or a both-edge design that drops them. Several corner cases are targeted. A kick that arrives inside the alarm before the minimum width is checked: a design without the pending flag would lose it and hold the alarm to its maximum, and one without the width floor would release at once. Inhibit raised early in an alarm is checked for the same floor. Glitches on kick and inhibit are checked: a missing qualifier would restart the timer or cut the alarm short. A restart with kick held high is checked: a qualifier seeded with the wrong level would count a phantom edge and shift the first alarm late.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // Phase reported on the status output; the values are part of the interface.
  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_RUN   = 2'd1,
    PH_ALARM = 2'd2
  } wdg_phase_e;

  // Trigger and alarm policy.
  typedef enum logic {
    TRIG_RISE = 1'b0,  // rising kicks only, alarm can be ended by a kick
    TRIG_BOTH = 1'b1   // both kick edges, fixed alarm length
  } wdg_trig_e;

  // Channel positions in the synchronizer vector.
  localparam int unsigned CH_KICK = 0;
  localparam int unsigned CH_INH  = 1;
  localparam int unsigned NUM_CH  = 2;

  // Nanoseconds to clock cycles, rounded up so no duration comes out short.
  function automatic longint unsigned ns_to_cyc(input longint unsigned ns,
                                                input longint unsigned clk_khz);
    return (ns * clk_khz + 64'd999_999) / 64'd1_000_000;
  endfunction

endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;

endmodule

// File: rtl/wdg_qual.sv
module wdg_qual #(
  parameter int unsigned CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic lvl_o,
  output logic ready_o
);

  localparam int unsigned   QW       = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [QW-1:0] CNT_LAST = QW'(CYC - 1);
  localparam logic [1:0]    WARM_END = 2'd3;

  logic [QW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic [1:0]    warm_q, warm_d;

  // Until the synchronizer holds real samples the level is copied straight
  // through, so the start-up level never counts as a transition.
  always_comb begin
    cnt_d  = cnt_q;
    lvl_d  = lvl_q;
    warm_d = warm_q;
    if (warm_q != WARM_END) begin
      lvl_d  = lvl_i;
      warm_d = warm_q + 2'd1;
      cnt_d  = '0;
    end else if (lvl_i == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_LAST) begin
      lvl_d = lvl_i;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
      warm_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
      warm_q <= warm_d;
    end
  end

  assign lvl_o   = lvl_q;
  assign ready_o = (warm_q == WARM_END);

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter wdg_trig_e   TRIG    = TRIG_BOTH,
  parameter int unsigned TO_CYC  = 5000,
  parameter int unsigned ALM_CYC = 2000,
  parameter int unsigned MIN_CYC = 1250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready_i,
  input  logic       kick_lvl_i,
  input  logic       inh_lvl_i,
  output logic       alarm_n_o,
  output logic [1:0] phase_o
);

  localparam int unsigned   MAX_CYC  = (TO_CYC > ALM_CYC) ? TO_CYC : ALM_CYC;
  localparam int unsigned   CW       = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CW-1:0] TO_LAST  = CW'(TO_CYC - 1);
  localparam logic [CW-1:0] ALM_LAST = CW'(ALM_CYC - 1);
  localparam logic [CW-1:0] MIN_LAST = CW'(MIN_CYC - 1);
  localparam logic          BOTH     = (TRIG == TRIG_BOTH);

  wdg_phase_e    ph_q, ph_d;
  logic [CW-1:0] tmr_q, tmr_d;
  logic          pend_q, pend_d;
  logic          prev_q;
  logic          armed_q;
  logic          alarm_n_q, alarm_n_d;

  logic kick_rise, kick_fall, kick_evt, min_done;

  // Edges exist only once both qualifiers are seeded and one compare cycle passed.
  assign kick_rise = armed_q &  kick_lvl_i & ~prev_q;
  assign kick_fall = armed_q & ~kick_lvl_i &  prev_q;
  assign kick_evt  = kick_rise | (BOTH & kick_fall);
  assign min_done  = (tmr_q >= MIN_LAST);

  always_comb begin
    ph_d   = ph_q;
    tmr_d  = tmr_q;
    pend_d = pend_q;
    unique case (ph_q)
      PH_OFF: begin
        tmr_d  = '0;
        pend_d = 1'b0;
        if (!inh_lvl_i) ph_d = PH_RUN;
      end
      PH_RUN: begin
        if (inh_lvl_i) begin
          ph_d  = PH_OFF;
          tmr_d = '0;
        end else if (kick_evt) begin
          tmr_d = '0;
        end else if (tmr_q == TO_LAST) begin
          ph_d   = PH_ALARM;
          tmr_d  = '0;
          pend_d = 1'b0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      PH_ALARM: begin
        if (!BOTH && kick_rise) pend_d = 1'b1;
        if (tmr_q == ALM_LAST) begin
          ph_d   = PH_RUN;
          tmr_d  = '0;
          pend_d = 1'b0;
        end else if (min_done && inh_lvl_i) begin
          ph_d   = PH_OFF;
          tmr_d  = '0;
          pend_d = 1'b0;
        end else if (!BOTH && min_done && (pend_q || kick_rise)) begin
          ph_d   = PH_RUN;
          tmr_d  = '0;
          pend_d = 1'b0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: begin
        ph_d   = PH_RUN;
        tmr_d  = '0;
        pend_d = 1'b0;
      end
    endcase
  end

  // The output register follows the next phase so it lines up with phase_o.
  assign alarm_n_d = (ph_d != PH_ALARM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_RUN;
      tmr_q     <= '0;
      pend_q    <= 1'b0;
      prev_q    <= 1'b0;
      armed_q   <= 1'b0;
      alarm_n_q <= 1'b1;
    end else begin
      ph_q      <= ph_d;
      tmr_q     <= tmr_d;
      pend_q    <= pend_d;
      prev_q    <= kick_lvl_i;
      armed_q   <= ready_i;
      alarm_n_q <= alarm_n_d;
    end
  end

  assign alarm_n_o = alarm_n_q;
  assign phase_o   = ph_q;

endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
  import wdg_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 125_000,
  parameter int unsigned TIMEOUT_NS = 1_600_000_000,
  parameter int unsigned ALARM_NS   = 210_000_000,
  parameter int unsigned MIN_LOW_NS = 10_000,
  parameter int unsigned QUAL_NS    = 400,
  parameter wdg_trig_e   TRIG       = TRIG_BOTH
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kick_i,
  input  logic       inhibit_i,
  output logic       alarm_n_o,
  output logic [1:0] phase_o
);

  localparam int unsigned TO_CYC   = 32'(ns_to_cyc(TIMEOUT_NS, CLK_KHZ));
  localparam int unsigned LONG_CYC = 32'(ns_to_cyc(ALARM_NS, CLK_KHZ));
  localparam int unsigned ALM_CYC  = (TRIG == TRIG_RISE) ? TO_CYC : LONG_CYC;
  localparam int unsigned MIN_CYC  = 32'(ns_to_cyc(MIN_LOW_NS, CLK_KHZ));
  localparam int unsigned QUAL_CYC = 32'(ns_to_cyc(QUAL_NS, CLK_KHZ));

  logic [NUM_CH-1:0] raw_async;
  logic [NUM_CH-1:0] raw_sync;
  logic [NUM_CH-1:0] lvl;
  logic [NUM_CH-1:0] ready;

  always_comb begin
    raw_async          = '0;
    raw_async[CH_KICK] = kick_i;
    raw_async[CH_INH]  = inhibit_i;
  end

  wdg_sync #(.W(NUM_CH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(raw_async),
    .sync_o (raw_sync)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_qual
    wdg_qual #(.CYC(QUAL_CYC)) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (raw_sync[ch]),
      .lvl_o  (lvl[ch]),
      .ready_o(ready[ch])
    );
  end

  wdg_timer #(
    .TRIG   (TRIG),
    .TO_CYC (TO_CYC),
    .ALM_CYC(ALM_CYC),
    .MIN_CYC(MIN_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready_i   (&ready),
    .kick_lvl_i(lvl[CH_KICK]),
    .inh_lvl_i (lvl[CH_INH]),
    .alarm_n_o (alarm_n_o),
    .phase_o   (phase_o)
  );

endmodule

// File: rtl/wdg_supervisor_chk.sv
module wdg_supervisor_chk
  import wdg_pkg::*;
#(
  parameter wdg_trig_e   TRIG    = TRIG_BOTH,
  parameter int unsigned TO_CYC  = 5000,
  parameter int unsigned ALM_CYC = 2000,
  parameter int unsigned MIN_CYC = 1250
) (
  input logic       clk,
  input logic       rst_n,
  input logic       alarm_n_o,
  input logic [1:0] phase_o
);

  int unsigned low_cnt;
  int unsigned high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= 0;
      high_cnt <= 0;
    end else if (!alarm_n_o) begin
      low_cnt  <= low_cnt + 1;
      high_cnt <= 0;
    end else begin
      low_cnt  <= 0;
      high_cnt <= high_cnt + 1;
    end
  end

  // R6
  high_before_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm_n_o) |-> high_cnt >= TO_CYC);

  // R8
  min_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_n_o) |-> low_cnt >= MIN_CYC);

  // R5
  alarm_max_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_n_o |-> low_cnt < ALM_CYC);

  // R4
  fixed_alarm_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (TRIG == TRIG_BOTH && $rose(alarm_n_o) && phase_o == PH_RUN) |-> low_cnt == ALM_CYC);

  // R7
  inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o == PH_OFF |-> alarm_n_o);

  // R10
  phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o != 2'd3);

endmodule

bind wdg_supervisor wdg_supervisor_chk #(
  .TRIG   (TRIG),
  .TO_CYC (TO_CYC),
  .ALM_CYC(ALM_CYC),
  .MIN_CYC(MIN_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .alarm_n_o(alarm_n_o),
  .phase_o  (phase_o)
);

// File: tb/wdg_supervisor_test.sv
module wdg_supervisor_test;
  import wdg_pkg::*;

  // 125 MHz: 5000 cycles timeout, 2000 alarm, 1250 min low, 50 qualify
  logic clk = 1'b0;
  logic rst_n, kick, inh;
  logic al_l, al_s;
  logic [1:0] ph_l, ph_s;

  always #4 clk = ~clk;

  wdg_supervisor #(.CLK_KHZ(125_000), .TIMEOUT_NS(40_000), .ALARM_NS(16_000),
                   .MIN_LOW_NS(10_000), .QUAL_NS(400), .TRIG(TRIG_BOTH)) uut (
    .clk(clk), .rst_n(rst_n), .kick_i(kick), .inhibit_i(inh),
    .alarm_n_o(al_l), .phase_o(ph_l));

  wdg_supervisor #(.CLK_KHZ(125_000), .TIMEOUT_NS(40_000), .ALARM_NS(16_000),
                   .MIN_LOW_NS(10_000), .QUAL_NS(400), .TRIG(TRIG_RISE)) uut_short (
    .clk(clk), .rst_n(rst_n), .kick_i(kick), .inhibit_i(inh),
    .alarm_n_o(al_s), .phase_o(ph_s));

  typedef struct packed {
    logic        kick;
    logic        inh;
    logic [15:0] hold;
    logic        exp_l;
    logic        exp_s;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  // Comments give the cycle count since reset release after each step.
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 16'd10,   1'b1, 1'b1, 4'd1},  // 10    R1 counting
    '{1'b0, 1'b0, 16'd4890, 1'b1, 1'b1, 4'd1},  // 4900  R1 not yet
    '{1'b0, 1'b0, 16'd200,  1'b0, 1'b0, 4'd1},  // 5100  R1 timeout, no kick
    '{1'b1, 1'b0, 16'd300,  1'b0, 1'b0, 4'd5},  // 5400  R5 early kick held
    '{1'b1, 1'b0, 16'd700,  1'b0, 1'b0, 4'd5},  // 6100  R5 min width
    '{1'b1, 1'b0, 16'd300,  1'b0, 1'b1, 4'd5},  // 6400  R5 released, R4 long held
    '{1'b0, 1'b0, 16'd500,  1'b0, 1'b1, 4'd4},  // 6900  R4 kicks ignored
    '{1'b0, 1'b0, 16'd200,  1'b1, 1'b1, 4'd4},  // 7100  R4 fixed end
    '{1'b1, 1'b0, 16'd2000, 1'b1, 1'b1, 4'd3},  // 9100  rising clears both
    '{1'b0, 1'b0, 16'd3300, 1'b1, 1'b0, 4'd2},  // 12400 R2 fall ignored / R3 fall clears
    '{1'b0, 1'b0, 16'd1900, 1'b0, 1'b0, 4'd6},  // 14300 R6
    '{1'b0, 1'b0, 16'd2000, 1'b1, 1'b0, 4'd4},  // 16300 R4 long ends
    '{1'b0, 1'b0, 16'd1000, 1'b1, 1'b1, 4'd5},  // 17300 R5 max one timeout
    '{1'b0, 1'b1, 16'd300,  1'b1, 1'b1, 4'd7},  // 17600 R7 inhibited
    '{1'b0, 1'b0, 16'd4800, 1'b1, 1'b1, 4'd7},  // 22400 R7 restart from zero
    '{1'b0, 1'b0, 16'd400,  1'b0, 1'b0, 4'd7},  // 22800 R7
    '{1'b0, 1'b1, 16'd500,  1'b0, 1'b0, 4'd8},  // 23300 R8 held low
    '{1'b0, 1'b1, 16'd800,  1'b1, 1'b1, 4'd8},  // 24100 R8 released
    '{1'b0, 1'b0, 16'd4000, 1'b1, 1'b1, 4'd7},  // 28100 R7
    '{1'b1, 1'b0, 16'd10,   1'b1, 1'b1, 4'd9},  // 28110 R9 kick glitch
    '{1'b0, 1'b0, 16'd1290, 1'b0, 1'b0, 4'd9},  // 29400 R9 glitch ignored
    '{1'b0, 1'b1, 16'd10,   1'b0, 1'b0, 4'd9},  // 29410 R9 inhibit glitch
    '{1'b0, 1'b0, 16'd1290, 1'b0, 1'b0, 4'd9},  // 30700 R9 glitch ignored
    '{1'b1, 1'b0, 16'd300,  1'b0, 1'b1, 4'd5},  // 31000 R5 late kick releases
    '{1'b1, 1'b0, 16'd300,  1'b1, 1'b1, 4'd4},  // 31300 R4
    '{1'b0, 1'b0, 16'd125,  1'b1, 1'b1, 4'd9},  // 31425 R9 1 us low pulse
    '{1'b1, 1'b0, 16'd4875, 1'b1, 1'b1, 4'd9},  // 36300 R9 pulse accepted
    '{1'b1, 1'b0, 16'd300,  1'b0, 1'b0, 4'd6}   // 36600 R6
  };

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100_000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=below %0d", cyc, 100_000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    kick  = 1'b0;
    inh   = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 reset alarm_n both-edge", int'(al_l), 1);
    chk("R10 reset phase both-edge", int'(ph_l), 1);
    chk("R10 reset phase rising", int'(ph_s), 1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      kick = VEC[i].kick;
      inh  = VEC[i].inh;
      repeat (int'(VEC[i].hold)) @(negedge clk);
      chk($sformatf("R%0d step %0d both-edge alarm_n", VEC[i].req, i),
          int'(al_l), int'(VEC[i].exp_l));
      chk($sformatf("R%0d step %0d rising alarm_n", VEC[i].req, i),
          int'(al_s), int'(VEC[i].exp_s));
    end

    // R1 / R10: restart with kick held high; the start level is no edge.
    rst_n = 1'b0;
    kick  = 1'b1;
    inh   = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 reset alarm_n rising", int'(al_s), 1);
    chk("R10 reset phase both-edge again", int'(ph_l), 1);
    rst_n = 1'b1;
    repeat (4990) @(negedge clk);
    chk("R1 high-start both-edge before timeout", int'(al_l), 1);
    chk("R1 high-start rising before timeout", int'(al_s), 1);
    repeat (40) @(negedge clk);
    chk("R1 high-start both-edge on time", int'(al_l), 0);
    chk("R1 high-start rising on time", int'(al_s), 0);
    chk("R10 alarm phase both-edge", int'(ph_l), 2);
    chk("R10 alarm phase rising", int'(ph_s), 2);

    // R8 / R10: inhibit early in the alarm, released after the min width.
    inh = 1'b1;
    repeat (1370) @(negedge clk);
    chk("R10 inhibited phase both-edge", int'(ph_l), 0);
    chk("R10 inhibited phase rising", int'(ph_s), 0);
    chk("R8 inhibited alarm_n both-edge", int'(al_l), 1);
    chk("R8 inhibited alarm_n rising", int'(al_s), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule